// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a SPI bus master that software drives through a small 32-bit register window. Frames that software writes into a transmit queue are shifted out on a serial clock and data pair. The programmable options are clock divider, frame length, clock polarity and phase, and bit order. Each frame that comes back on the input line is put into a receive queue, and a read of the data port takes it out. Four chip-select outputs exist. Software picks one of them and its level through a control field, so a transaction can span any number of frames.

The transmit queue is only drained while the core enable and transmit enable bits are both set. Received frames are only kept while receive enable is set. An output-enable bit decides whether the data line carries the frame bits or is held low. A loopback option feeds the outgoing line back to the sampler so the block can check itself without a slave. The register port has no back-pressure: every access completes in the cycle it is presented. A push to a full transmit queue is dropped, and a pop from an empty receive queue is dropped. Software polls the status counts and the busy flag to stay within the queue limits. It waits for busy to fall before it releases chip select.

Top module: `spim_ctrl`

## Requirements
- R1: After reset all control registers read 0, SCLK is low, all four chip-select pins are low and MOSI is low.
- R2: Offset 0x60 reads the revision constant (default 0x00020100). Offset 0x64 reads queue depth minus one in bits [15:8] (receive) and [23:16] (transmit), with bit 26 set. With the default depth of 16 it reads 0x040F0F00.
- R3: A write to offset 0x18 pushes the low L bits of the write data into the transmit queue. L is control 1 bits [20:16] plus one. A push into a full queue (16 entries) is ignored.
- R4: A read of offset 0x18 returns the oldest received frame, zero-extended, and removes it from the queue. A read with the receive queue empty returns 0 and changes nothing.
- R5: Status at offset 0x0C holds the following: receive full in bit 0, transmit not full in bit 1, busy in bit 2, receive count in [8:4] and transmit count in [16:12].
- R6: During a frame every SCLK half period lasts DIV+1 clocks, where DIV is control 1 bits [15:0]. A frame has exactly 2L SCLK edges. While idle, SCLK rests at control 0 bit 1.
- R7: Bit order and sampling follow control 0. Bit 6 set sends the LSB first, otherwise the MSB is sent first. Bit 0 clear samples MISO on the leading SCLK edge. Bit 0 set samples MISO on the trailing SCLK edge.
- R8: Control 0 bit 7 loops MOSI back to the receive sampler in place of MISO.
- R9: Frames leave the transmit queue only while control 2 bit 0 (enable) and bit 8 (transmit enable) are both set. While control 2 bit 1 (data output enable) is clear, MOSI stays low.
- R10: A completed frame is stored in the receive queue only if control 2 bit 7 (receive enable) is set and the queue is not full. Otherwise the frame is discarded.
- R11: Control 2 bits [11:10] select one of four chip-select pins, and bit 9 asserts it. When control 0 bit 5 is set the pins are active low. Unselected pins stay deasserted.
- R12: Writing 1 to control 2 bit 3 empties the transmit queue. Writing 1 to bit 2 empties the receive queue. Both bits read back as 0.
- R13: Busy is set while a frame is shifting, or while the core is enabled and the transmit queue holds data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the data port) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current address |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_pin | output | 4 | Chip-select pins |

## Verification
The assertions assume that each read or write strobe lasts one clock and that the data-port pop strobe appears only with the data offset. They also assume that MISO is stable on the SCLK edges where it is sampled. The bench drives each access for exactly one clock, from the falling clock edge. Its slave model changes MISO one time step after a sampling edge, so the value that will be sampled is in place a full half period ahead. The bench also reprograms control 0 and control 1 only while busy is low, because the queue-count and phase checks assume the frame configuration does not change mid-frame.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int P_DIVW = 16;
  localparam int P_LENW = 5;
  localparam int P_FW   = 2 ** P_LENW;
  localparam int P_CSW  = 2;
  localparam int P_NCS  = 2 ** P_CSW;

  localparam logic [7:0] OFS_CTL0 = 8'h00;
  localparam logic [7:0] OFS_CTL1 = 8'h04;
  localparam logic [7:0] OFS_CTL2 = 8'h08;
  localparam logic [7:0] OFS_STAT = 8'h0C;
  localparam logic [7:0] OFS_DATA = 8'h18;
  localparam logic [7:0] OFS_REV  = 8'h60;
  localparam logic [7:0] OFS_FEAT = 8'h64;

  typedef struct packed {
    logic              lsb_first;
    logic              cpol;
    logic              cpha;
    logic [P_LENW-1:0] len_m1;
    logic [P_DIVW-1:0] div;
  } shift_cfg_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rptr_q];
  assign count   = cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wptr_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (clr) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= nxt(wptr_q);
      if (do_pop)  rptr_q <= nxt(rptr_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  AST_FULL_PUSH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clr) |=> (count == $past(count))); // R3
  AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !clr) |=> (count == $past(count))); // R4
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R5
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
  import spim_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  shift_cfg_t      cfg_i,
  input  logic            start_i,
  input  logic [P_FW-1:0] tx_word_i,
  input  logic            miso_i,
  output logic            active_o,
  output logic            sclk_o,
  output logic            mosi_bit_o,
  output logic            done_o,
  output logic [P_FW-1:0] rx_word_o
);
  shift_cfg_t        cfg_q;
  logic              active_q, phase_q, done_q;
  logic [P_DIVW-1:0] dcnt_q;
  logic [P_LENW:0]   hcnt_q;
  logic [P_LENW-1:0] bit_q, pos;
  logic [P_FW-1:0]   tx_q, rx_q;
  logic              half_end, last_half, lead, do_shift, do_sample;

  assign pos       = cfg_q.lsb_first ? bit_q : cfg_q.len_m1 - bit_q;
  assign half_end  = active_q && (dcnt_q == cfg_q.div);
  assign last_half = (hcnt_q == {cfg_q.len_m1, 1'b1});
  assign lead      = !hcnt_q[0];
  assign do_shift  = half_end && (cfg_q.cpha ? (lead && hcnt_q != '0) : (!lead && !last_half));
  assign do_sample = half_end && (cfg_q.cpha ? !lead : lead);

  assign active_o   = active_q;
  assign sclk_o     = active_q ? (cfg_q.cpol ^ phase_q) : cfg_i.cpol;
  assign mosi_bit_o = tx_q[pos];
  assign done_o     = done_q;
  assign rx_word_o  = rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      done_q   <= 1'b0;
      dcnt_q   <= '0;
      hcnt_q   <= '0;
      bit_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !active_q) begin
        cfg_q    <= cfg_i;
        active_q <= 1'b1;
        phase_q  <= 1'b0;
        dcnt_q   <= '0;
        hcnt_q   <= '0;
        bit_q    <= '0;
        tx_q     <= tx_word_i;
        rx_q     <= '0;
      end else if (active_q) begin
        if (do_sample) rx_q[pos] <= miso_i;
        if (do_shift)  bit_q <= bit_q + 1'b1;
        if (half_end) begin
          dcnt_q  <= '0;
          phase_q <= !phase_q;
          if (last_half) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            hcnt_q <= hcnt_q + 1'b1;
          end
        end else begin
          dcnt_q <= dcnt_q + 1'b1;
        end
      end
    end
  end

  AST_HALF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && dcnt_q != cfg_q.div) |=> (phase_q == $past(phase_q))); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R6
  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !active_q); // R9
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int          FIFO_DEPTH = 16,
  parameter logic [31:0] REV_ID     = 32'h0002_0100,
  localparam int         CW         = $clog2(FIFO_DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic [P_NCS-1:0] cs_pin
);
  logic [7:0]        ctl0_q;
  logic [P_DIVW-1:0] div_q;
  logic [P_LENW-1:0] len_q;
  logic [11:0]       ctl2_q;

  wire en_w   = ctl2_q[0];
  wire txoe_w = ctl2_q[1];
  wire rxen_w = ctl2_q[7];
  wire txen_w = ctl2_q[8];
  wire cslv_w = ctl2_q[9];
  wire [P_CSW-1:0] cssel_w = ctl2_q[11:10];
  wire cslow_w = ctl0_q[5];
  wire loop_w  = ctl0_q[7];

  logic            tx_push, tx_clr, rx_pop, rx_clr, start, busy;
  logic            tx_full, tx_empty, rx_full, rx_empty;
  logic [CW-1:0]   tx_cnt, rx_cnt;
  logic [P_FW-1:0] tx_head, rx_head, frame_mask, rx_word;
  logic            sh_active, sh_done, mosi_bit, sample_in;
  shift_cfg_t      cfg;

  assign tx_push    = reg_wr && (reg_addr == OFS_DATA);
  assign tx_clr     = reg_wr && (reg_addr == OFS_CTL2) && reg_wdata[3];
  assign rx_clr     = reg_wr && (reg_addr == OFS_CTL2) && reg_wdata[2];
  assign rx_pop     = reg_rd && (reg_addr == OFS_DATA);
  assign frame_mask = {P_FW{1'b1}} >> (P_LENW'(P_FW - 1) - len_q);
  assign start      = en_w && txen_w && !tx_empty && !sh_active;
  assign busy       = sh_active || (en_w && !tx_empty);

  assign cfg.lsb_first = ctl0_q[6];
  assign cfg.cpol      = ctl0_q[1];
  assign cfg.cpha      = ctl0_q[0];
  assign cfg.len_m1    = len_q;
  assign cfg.div       = div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl0_q <= '0;
      div_q  <= '0;
      len_q  <= '0;
      ctl2_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_CTL0: ctl0_q <= reg_wdata[7:0] & 8'hE3;
        OFS_CTL1: begin
          div_q <= reg_wdata[P_DIVW-1:0];
          len_q <= reg_wdata[16 +: P_LENW];
        end
        OFS_CTL2: ctl2_q <= reg_wdata[11:0] & 12'hF83;
        default: ;
      endcase
    end
  end

  spim_fifo #(.W(P_FW), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr), .push(tx_push),
    .wdata(reg_wdata[P_FW-1:0] & frame_mask), .pop(start), .rdata(tx_head),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  spim_fifo #(.W(P_FW), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(sh_done && rxen_w),
    .wdata(rx_word), .pop(rx_pop), .rdata(rx_head),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty));

  assign mosi      = txoe_w && mosi_bit;
  assign sample_in = loop_w ? mosi : miso;

  spim_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .start_i(start), .tx_word_i(tx_head),
    .miso_i(sample_in), .active_o(sh_active), .sclk_o(sclk), .mosi_bit_o(mosi_bit),
    .done_o(sh_done), .rx_word_o(rx_word));

  for (genvar g = 0; g < P_NCS; g++) begin : g_cs
    wire asserted = (cssel_w == P_CSW'(g)) && cslv_w;
    assign cs_pin[g] = cslow_w ? !asserted : asserted;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CTL0: reg_rdata[7:0] = ctl0_q;
      OFS_CTL1: begin
        reg_rdata[P_DIVW-1:0]   = div_q;
        reg_rdata[16 +: P_LENW] = len_q;
      end
      OFS_CTL2: reg_rdata[11:0] = ctl2_q;
      OFS_STAT: begin
        reg_rdata[0]     = rx_full;
        reg_rdata[1]     = !tx_full;
        reg_rdata[2]     = busy;
        reg_rdata[8:4]   = 5'(rx_cnt);
        reg_rdata[16:12] = 5'(tx_cnt);
      end
      OFS_DATA: reg_rdata[P_FW-1:0] = rx_empty ? '0 : rx_head;
      OFS_REV:  reg_rdata = REV_ID;
      OFS_FEAT: begin
        reg_rdata[15:8]  = 8'(FIFO_DEPTH - 1);
        reg_rdata[23:16] = 8'(FIFO_DEPTH - 1);
        reg_rdata[26]    = 1'b1;
      end
      default: ;
    endcase
  end

  AST_RX_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_done && rxen_w && !rx_full && !rx_clr && !rx_pop) |=> (rx_cnt == $past(rx_cnt) + 1'b1)); // R10
  AST_RX_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_done && !rxen_w && !rx_clr && !rx_pop) |=> (rx_cnt == $past(rx_cnt))); // R10
  AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cslow_w |-> $onehot0(cs_pin)); // R11
  AST_NO_SHIFT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ((!en_w || !txen_w) && !sh_active) |=> !sh_active); // R9
endmodule

// File: tb/spim_ctrl_tb_top.sv
module spim_ctrl_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, miso = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        sclk, mosi;
  logic [3:0]  cs_pin;

  int n_chk = 0, n_bad = 0;

  spim_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_pin(cs_pin));

  always #(CLK_P / 2) clk = !clk;

  // slave and SCLK monitor
  logic        mon_on = 1'b0, m_cpol = 1'b0, m_cpha = 1'b0, m_lsb = 1'b0, have_last = 1'b0;
  int          m_len = 8, sidx = 0, n_edges = 0;
  logic [31:0] cap = '0, slave_word = '0;
  time         last_t = 0, min_h = 0, max_h = 0;

  function automatic int bpos(input int b);
    return m_lsb ? b : m_len - 1 - b;
  endfunction

  always @(sclk) begin
    if (mon_on) begin
      n_edges++;
      if (have_last) begin
        if ($time - last_t < min_h) min_h = $time - last_t;
        if ($time - last_t > max_h) max_h = $time - last_t;
      end
      have_last = 1'b1;
      last_t = $time;
      if (((sclk != m_cpol) != m_cpha) && sidx < m_len) begin
        cap[bpos(sidx)] = mosi;
        sidx++;
        #1;
        if (sidx < m_len) miso = slave_word[bpos(sidx)];
      end
    end
  end

  task automatic mon_start(input logic cpol, cpha, lsb, input int len, input logic [31:0] sw);
    m_cpol = cpol; m_cpha = cpha; m_lsb = lsb; m_len = len; slave_word = sw;
    sidx = 0; cap = '0; n_edges = 0; have_last = 1'b0; min_h = 1000000; max_h = 0;
    miso = sw[bpos(0)];
    mon_on = 1'b1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(8'h0C, s);
      if (!s[2]) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h00, d); chk("R1 ctl0", d, 0);
    rd(8'h04, d); chk("R1 ctl1", d, 0);
    rd(8'h08, d); chk("R1 ctl2", d, 0);
    chk("R1 pins", {27'b0, sclk, mosi, cs_pin}, 0);
    rd(8'h0C, d); chk("R5 reset status", d, 32'h2);
    rd(8'h60, d); chk("R2 revision", d, 32'h0002_0100);
    rd(8'h64, d); chk("R2 feature", d, 32'h040F_0F00);
  endtask

  task automatic t_loopback();
    logic [31:0] d;
    wr(8'h00, 32'h80);
    wr(8'h04, (7 << 16) | 1);
    mon_start(0, 0, 0, 8, 0);
    wr(8'h08, 32'h183);
    wr(8'h18, 32'h1A5);
    rd(8'h0C, d); chk("R13 busy while shifting", d & 4, 4);
    wait_idle();
    chk("R3 masked frame on MOSI", cap, 32'hA5);
    chk("R6 edge count", n_edges, 16);
    chk("R6 half period min", 32'(min_h), 2 * CLK_P);
    chk("R6 half period max", 32'(max_h), 2 * CLK_P);
    rd(8'h0C, d); chk("R5 status one rx", d, 32'h12);
    rd(8'h18, d); chk("R8 loopback data", d, 32'hA5);
    rd(8'h0C, d); chk("R4 popped", d, 32'h2);
    mon_on = 1'b0;
  endtask

  task automatic run_ext(input string tag, input logic [7:0] c0, input int div, len,
                         input logic [31:0] txw, sw);
    logic [31:0] d;
    wr(8'h00, {24'b0, c0});
    wr(8'h04, ((len - 1) << 16) | div);
    chk({tag, " R6 idle level"}, sclk, c0[1]);
    mon_start(c0[1], c0[0], c0[6], len, sw);
    wr(8'h08, 32'h183);
    wr(8'h18, txw);
    wait_idle();
    chk({tag, " R7 mosi bits"}, cap, txw);
    chk({tag, " R6 edges"}, n_edges, 2 * len);
    chk({tag, " R6 half"}, 32'(max_h), (div + 1) * CLK_P);
    chk({tag, " R6 idle after"}, sclk, c0[1]);
    rd(8'h18, d); chk({tag, " R7 received"}, d, sw);
    mon_on = 1'b0;
  endtask

  task automatic t_fifo();
    logic [31:0] d;
    wr(8'h00, 32'h0);
    wr(8'h04, (7 << 16));
    wr(8'h08, 32'h102);
    for (int i = 0; i < 17; i++) wr(8'h18, i);
    rd(8'h0C, d); chk("R3 full push ignored", d, 32'h10000);
    rd(8'h18, d); chk("R4 empty pop", d, 0);
    rd(8'h0C, d); chk("R4 counts kept", d, 32'h10000);
    mon_start(0, 0, 0, 8, 0);
    wr(8'h08, 32'h003);
    repeat (40) @(negedge clk);
    chk("R9 no edges without tx enable", n_edges, 0);
    rd(8'h0C, d); chk("R13 busy with data queued", d, 32'h10004);
    mon_on = 1'b0;
    wr(8'h08, 32'h00B);
    rd(8'h0C, d); chk("R12 tx cleared", d, 32'h2);
    rd(8'h08, d); chk("R12 clear bit reads 0", d, 32'h3);
  endtask

  task automatic t_txoe_rxen();
    logic [31:0] d;
    wr(8'h00, 32'h80);
    wr(8'h04, (7 << 16));
    mon_start(0, 0, 0, 8, 0);
    wr(8'h08, 32'h181);
    wr(8'h18, 32'hFF);
    wait_idle();
    chk("R9 mosi held low", cap, 0);
    rd(8'h18, d); chk("R9 loopback of low line", d, 0);
    mon_on = 1'b0;
    wr(8'h08, 32'h103);
    wr(8'h18, 32'h77);
    wait_idle();
    rd(8'h0C, d); chk("R10 frame discarded", d, 32'h2);
  endtask

  task automatic t_rxfull();
    logic [31:0] d;
    wr(8'h08, 32'h183);
    for (int i = 0; i < 17; i++) wr(8'h18, 32'h10 + i);
    wait_idle();
    rd(8'h0C, d); chk("R5 rx full status", d, 32'h103);
    rd(8'h18, d); chk("R10 oldest kept", d, 32'h10);
    wr(8'h08, 32'h187);
    rd(8'h0C, d); chk("R12 rx cleared", d, 32'h2);
  endtask

  task automatic t_cs();
    wr(8'h00, 32'h0);
    wr(8'h08, (2 << 10) | (1 << 9));
    chk("R11 active high", cs_pin, 4'b0100);
    wr(8'h00, 32'h20);
    chk("R11 active low", cs_pin, 4'b1011);
    wr(8'h08, (2 << 10));
    chk("R11 released", cs_pin, 4'b1111);
    wr(8'h08, (3 << 10) | (1 << 9));
    chk("R11 select 3", cs_pin, 4'b0111);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_loopback();
    run_ext("lsb cpol1 cpha1", 8'h43, 2, 10, 32'h2B7, 32'h3C5);
    run_ext("msb mode0", 8'h00, 0, 16, 32'h1234, 32'hBEEF);
    run_ext("msb cpha1", 8'h01, 1, 8, 32'hC3, 32'h5A);
    t_fifo();
    t_txoe_rxen();
    t_rxfull();
    t_cs();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule